// File: doc/BRIEF.md
# Configurable External Interrupt Combiner

This block gathers the interrupt requests of a group of port pins into a single request line for the processor. Software enables pins one by one as interrupt sources. The enabled pins, once synchronised to the block clock, are combined with a logical AND into one active-low event signal. A pin that is not enabled reads as inactive high. A trigger detector then watches that combined signal in one of four modes. Edge events set a pending flag that holds the request until the processor acknowledges it. In the mixed mode, the request also follows a low level for as long as the level lasts.

A small control register holds the two trigger-mode bits and a slow-clock bit. The mode bits accept a write only while the processor's global interrupt mask is set. A write at any other time leaves them unchanged. The slow bit turns the block's clock-enable output from every cycle into one pulse per 64 cycles. Entry into halt clears the slow bit on its own. Because the pins share one AND, a second event that overlaps an event still in progress on another pin cannot be seen.

Top module: `irq_combiner`

## Requirements
- R1: Each pin passes through a two-flop synchroniser. An edge that is drawn into the pending flag shows on `irq_o` after the third rising clock edge that follows the pin change. A low level in the level-sensitive mode shows after the second.
- R2: Mode 01 (register bit 6 = 0, bit 5 = 1) latches a request on a falling edge of the combined signal only. Rising edges and steady levels do not raise `irq_o`.
- R3: Mode 10 (bit 6 = 1, bit 5 = 0) latches a request on a rising edge of the combined signal only.
- R4: Mode 11 latches a request on both rising and falling edges of the combined signal.
- R5: Mode 00 latches a request on a falling edge, and it also drives `irq_o` high for as long as the combined signal is low. A low pulse as short as one clock still leaves a latched request.
- R6: A latched request holds `irq_o` high until `ack_i` is high for one clock. It drops in the cycle after the acknowledge, unless mode 00 still sees a low level.
- R7: The combined signal is the AND of all enabled synchronised pins. Pins whose enable is 0 have no effect, and with no pin enabled the signal stays high. A low on a second enabled pin while the first is still low produces no new request.
- R8: The control register reads 0x00 after reset. A write updates bits 6 and 5 only when `mask_i` is 1 in the write cycle, and otherwise leaves them at their old value. Bit 1 is written in either case. All other bits read 0.
- R9: When bit 1 is 0, `tick_o` is high in every cycle. When bit 1 is 1, `tick_o` pulses once every 64 cycles.
- R10: A `halt_i` pulse clears bit 1 on the next edge. It takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | N_PINS | Raw pin levels, asynchronous |
| pin_en_i | input | N_PINS | Per-pin interrupt enable |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| mask_i | input | 1 | Processor global interrupt mask, 1 = masked |
| halt_i | input | 1 | Halt entry pulse |
| ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Interrupt request to the processor |
| reg_o | output | 8 | Control register read value |
| tick_o | output | 1 | Clock enable, divided by 64 in slow mode |

## Verification
The assertions assume that `rst_n` is asserted at time zero. They also assume that `mask_i`, the write strobe, `halt_i` and `ack_i` change only between clock edges, so that a $past or $stable comparison refers to a settled value. The bench drives every input on the falling clock edge and holds each pin level for at least one full cycle. It always writes the mode bits while the pins are idle, so a mode change never coincides with an edge on the combined signal. The acknowledge assertion covers only cycles with no fresh edge, because a new edge in the same cycle is allowed to win.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [1:0] {
        TRIG_LOW_FALL = 2'b00,
        TRIG_FALL     = 2'b01,
        TRIG_RISE     = 2'b10,
        TRIG_BOTH     = 2'b11
    } trig_mode_e;

    localparam int REG_W       = 8;
    localparam int MODE_HI_BIT = 6;
    localparam int MODE_LO_BIT = 5;
    localparam int SLOW_BIT    = 1;
endpackage

// File: rtl/irqc_sync_and.sv
module irqc_sync_and #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic [N_PINS-1:0] en_i,
    output logic              comb_o
);
    typedef struct packed {
        logic [N_PINS-1:0] s1;
        logic [N_PINS-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;
    logic [N_PINS-1:0] masked;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
    end

    genvar g;
    generate
        for (g = 0; g < N_PINS; g++) begin : g_mask
            assign masked[g] = st_q.s2[g] | ~en_i[g];
        end
    endgenerate

    assign comb_o = &masked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    // R7: a low synchronised enabled pin forces the combined signal low
    a_r7_low_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.s2 & en_i) != en_i) |-> !comb_o);
endmodule

// File: rtl/irqc_trig.sv
module irqc_trig
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       comb_i,
    input  trig_mode_e mode_i,
    input  logic       ack_i,
    output logic       irq_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } trig_t;

    trig_t st_d, st_q;
    logic  fall, rise, hit;

    always_comb begin
        fall = st_q.prev & ~comb_i;
        rise = ~st_q.prev & comb_i;
        unique case (mode_i)
            TRIG_LOW_FALL: hit = fall;
            TRIG_FALL:     hit = fall;
            TRIG_RISE:     hit = rise;
            TRIG_BOTH:     hit = fall | rise;
            default:       hit = 1'b0;
        endcase
        st_d      = st_q;
        st_d.prev = comb_i;
        if (hit)        st_d.pend = 1'b1;
        else if (ack_i) st_d.pend = 1'b0;
    end

    assign irq_o = st_q.pend | ((mode_i == TRIG_LOW_FALL) & ~comb_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b1, pend: 1'b0};
        else        st_q <= st_d;
    end

    a_r2_fall_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TRIG_FALL && st_q.prev && !comb_i) |=> irq_o);
    a_r3_rise_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TRIG_RISE && !st_q.prev && comb_i) |=> irq_o);
    a_r5_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TRIG_LOW_FALL && !comb_i) |-> irq_o);
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !hit) |=> !st_q.pend);
endmodule

// File: rtl/irqc_clkdiv.sv
module irqc_clkdiv #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!slow_i)            cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
    end

    assign tick_o = ~slow_i | (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9: in slow mode two ticks never follow each other
    a_r9_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_i && tick_o) |=> (!tick_o || !slow_i));
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             mask_i,
    input  logic             halt_i,
    output trig_mode_e       mode_o,
    output logic             slow_o,
    output logic [REG_W-1:0] reg_o
);
    typedef struct packed {
        logic [1:0] mode;
        logic       slow;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.slow = wdata_i[SLOW_BIT];
            if (mask_i) st_d.mode = {wdata_i[MODE_HI_BIT], wdata_i[MODE_LO_BIT]};
        end
        if (halt_i) st_d.slow = 1'b0;
    end

    always_comb begin
        reg_o              = '0;
        reg_o[MODE_HI_BIT] = st_q.mode[1];
        reg_o[MODE_LO_BIT] = st_q.mode[0];
        reg_o[SLOW_BIT]    = st_q.slow;
    end

    assign mode_o = trig_mode_e'(st_q.mode);
    assign slow_o = st_q.slow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r8_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !mask_i) |=> $stable(mode_o));
    a_r10_halt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> !slow_o);
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irqc_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int DIV    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic [N_PINS-1:0] pin_en_i,
    input  logic              reg_we_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    input  logic              mask_i,
    input  logic              halt_i,
    input  logic              ack_i,
    output logic              irq_o,
    output logic [REG_W-1:0]  reg_o,
    output logic              tick_o
);
    logic       comb;
    logic       slow;
    trig_mode_e mode;

    irqc_sync_and #(.N_PINS(N_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .en_i(pin_en_i), .comb_o(comb)
    );

    irqc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
        .mask_i(mask_i), .halt_i(halt_i), .mode_o(mode), .slow_o(slow), .reg_o(reg_o)
    );

    irqc_trig u_trig (
        .clk(clk), .rst_n(rst_n), .comb_i(comb), .mode_i(mode), .ack_i(ack_i), .irq_o(irq_o)
    );

    irqc_clkdiv #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .slow_i(slow), .tick_o(tick_o)
    );
endmodule

// File: tb/tb_irq_combiner.sv
module tb_irq_combiner;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin = '1;
    logic [N-1:0] en = '0;
    logic         we = 1'b0;
    logic [7:0]   wdata = '0;
    logic         mask = 1'b0;
    logic         halt = 1'b0;
    logic         ack = 1'b0;
    logic         irq;
    logic [7:0]   regv;
    logic         tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irq_combiner #(.N_PINS(N), .DIV(64)) dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .pin_en_i(en),
        .reg_we_i(we), .reg_wdata_i(wdata), .mask_i(mask), .halt_i(halt),
        .ack_i(ack), .irq_o(irq), .reg_o(regv), .tick_o(tick)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d, input logic m);
        we = 1'b1; wdata = d; mask = m;
        cyc(1);
        we = 1'b0; mask = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8 reset reg", regv, 8'h00);
        chk("R6 reset irq", {7'd0, irq}, 8'd0);
        chk("R9 reset tick", {7'd0, tick}, 8'd1);
    endtask

    task automatic t_falling();
        wr(8'h20, 1'b1);
        chk("R8 mode write", regv, 8'h20);
        en = 8'h01;
        pin[0] = 1'b0;
        cyc(2);
        chk("R1 not yet", {7'd0, irq}, 8'd0);
        cyc(1);
        chk("R1 R2 fall latched", {7'd0, irq}, 8'd1);
        cyc(3);
        chk("R6 held", {7'd0, irq}, 8'd1);
        do_ack();
        chk("R6 ack clears", {7'd0, irq}, 8'd0);
        pin[0] = 1'b1;
        cyc(4);
        chk("R2 rise ignored", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_rising();
        wr(8'h40, 1'b1);
        pin[0] = 1'b0;
        cyc(4);
        chk("R3 fall ignored", {7'd0, irq}, 8'd0);
        pin[0] = 1'b1;
        cyc(3);
        chk("R3 rise latched", {7'd0, irq}, 8'd1);
        do_ack();
        chk("R6 ack rise", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_both();
        wr(8'h60, 1'b1);
        pin[0] = 1'b0;
        cyc(3);
        chk("R4 fall", {7'd0, irq}, 8'd1);
        do_ack();
        pin[0] = 1'b1;
        cyc(2);
        chk("R4 gap", {7'd0, irq}, 8'd0);
        cyc(1);
        chk("R4 rise", {7'd0, irq}, 8'd1);
        do_ack();
        chk("R4 ack", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_level();
        wr(8'h00, 1'b1);
        chk("R8 mode 00", regv, 8'h00);
        pin[0] = 1'b0;
        cyc(1);
        chk("R1 level early", {7'd0, irq}, 8'd0);
        cyc(1);
        chk("R5 level", {7'd0, irq}, 8'd1);
        cyc(2);
        do_ack();
        chk("R5 ack during low", {7'd0, irq}, 8'd1);
        pin[0] = 1'b1;
        cyc(2);
        chk("R5 level gone", {7'd0, irq}, 8'd0);
        pin[0] = 1'b0;
        cyc(1);
        pin[0] = 1'b1;
        cyc(5);
        chk("R5 short pulse latched", {7'd0, irq}, 8'd1);
        do_ack();
        chk("R6 pulse ack", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_and();
        wr(8'h20, 1'b1);
        en = 8'h03;
        pin[0] = 1'b0;
        cyc(3);
        chk("R7 first pin", {7'd0, irq}, 8'd1);
        do_ack();
        pin[1] = 1'b0;
        cyc(4);
        chk("R7 overlap lost", {7'd0, irq}, 8'd0);
        pin[1:0] = 2'b11;
        cyc(3);
        pin[2] = 1'b0;
        cyc(4);
        chk("R7 disabled pin", {7'd0, irq}, 8'd0);
        pin[2] = 1'b1;
        en = 8'h00;
        pin[0] = 1'b0;
        cyc(4);
        chk("R7 none enabled", {7'd0, irq}, 8'd0);
        pin[0] = 1'b1;
        en = 8'h01;
        cyc(3);
    endtask

    task automatic t_lock();
        wr(8'h60, 1'b0);
        chk("R8 locked", regv, 8'h20);
        pin[0] = 1'b0;
        cyc(3);
        do_ack();
        pin[0] = 1'b1;
        cyc(4);
        chk("R8 locked mode rise ignored", {7'd0, irq}, 8'd0);
        wr(8'h60, 1'b1);
        chk("R8 unlocked", regv, 8'h60);
    endtask

    task automatic t_slow();
        int n;
        wr(8'h02, 1'b0);
        chk("R9 slow bit", regv, 8'h62);
        n = 0;
        for (int i = 0; i < 128; i++) begin
            if (tick) n++;
            cyc(1);
        end
        chk("R9 slow ticks", n[7:0], 8'd2);
        halt = 1'b1;
        cyc(1);
        halt = 1'b0;
        chk("R10 halt clears", regv, 8'h60);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            if (tick) n++;
            cyc(1);
        end
        chk("R9 fast ticks", n[7:0], 8'd10);
        we = 1'b1; wdata = 8'h02; halt = 1'b1;
        cyc(1);
        we = 1'b0; halt = 1'b0;
        chk("R10 halt beats write", regv, 8'h60);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_falling();
        t_rising();
        t_both();
        t_level();
        t_and();
        t_lock();
        t_slow();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule